// File: doc/BRIEF.md
# Self-Testing NAND Network with Pattern Generator and Signature Compactor

This block is a built-in self-test wrapper around a small three-input NAND network. A pulse on `start` loads a fixed seed into two registers. The first is a 3-bit maximal-length pattern generator, which drives the network's inputs. The second is a 3-bit multiple-input signature register, which folds the network's three outputs into its state on every clock. Seven patterns are applied, one per clock. The state left in the signature register is then compared with a golden value given as a parameter, and the result is shown on `pass` and `fail`.

A two-bit fault selector can force the first input of the network's second NAND gate to a constant 1 or 0. This lets a user confirm that the compaction exposes both stuck-at faults. The selector is meant to be held steady for the whole run.

Top module: `bist_misr_top`

## Requirements
- R1: After synchronous reset, busy, done, pass and fail are 0 and signature reads the seed 3'b101.
- R2: A start pulse seen while idle makes busy 1 on the next clock, loads both the pattern register and the signature register with 3'b101, and clears pass and fail.
- R3: The pattern register shifts left and takes bit2 XOR bit1 into bit0 (polynomial x^3+x^2+1). From the seed it visits 101, 011, 111, 110, 100, 001, 010 and never reaches zero.
- R4: The network takes a = pattern bit2, b = bit1 and c = bit0. Its outputs are y0 = NAND(a,b), y1 = NAND(g,c) and y2 = NAND(y0,y1), where g is y0 when no fault is injected.
- R5: On each busy clock the signature state q is replaced by {q1^q2^y2, q0^y1, q2^y0}. A stage with no network output wired to it receives no input XOR.
- R6: busy stays 1 for exactly seven clocks, so the signature passes through eight states counting the seed. The last of these states is the signature.
- R7: done is a single-cycle pulse in the clock after the seventh compaction, and busy falls in that same clock.
- R8: When done rises, pass is 1 and fail is 0 if the signature equals the golden parameter; otherwise fail is 1 and pass is 0. Both hold, together with the signature, until the next accepted start.
- R9: fault_sel 0 selects no fault, 1 forces g to 1 (stuck-at-1) and 2 forces g to 0 (stuck-at-0). Code 3 behaves as no fault.
- R10: A start pulse during a run has no effect on the sequence of signature states or on the run length.
- R11: With the default seeds and a golden value taken from a fault-free run, both the stuck-at-1 run and the stuck-at-0 run end with fail set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a self-test run when idle |
| fault_sel | input | 2 | Fault injected on the second gate's first input: 0 none, 1 stuck-at-1, 2 stuck-at-0, 3 none |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run finishes |
| pass | output | 1 | The last run matched the golden signature |
| fail | output | 1 | The last run did not match the golden signature |
| signature | output | SIG_W | Current signature register state |

## Verification
The bench runs the block with every code of the fault selector: fault-free, stuck-at-1, stuck-at-0 and the reserved code. After each clock of each run it compares the signature with a state computed by its own arithmetic model. A fault-free run confirms the pattern order, the network function and the compaction. The two fault runs confirm that each fault produces its own distinct final state, different from the golden one. The reserved code is shown to give the fault-free result. Further runs send a start pulse in the middle of a run, to show it does not disturb the sequence, and leave the block idle afterwards, to show that the verdict and the signature hold.

// File: rtl/bist_pkg.sv
package bist_pkg;
   localparam int CUT_IN  = 3;
   localparam int CUT_OUT = 3;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_SA1  = 2'd1,
      FLT_SA0  = 2'd2,
      FLT_RSV  = 2'd3
   } fault_e;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_e;
endpackage

// File: rtl/bist_pattern_lfsr.sv
module bist_pattern_lfsr #(
   parameter int           W    = 3,
   parameter logic [W-1:0] SEED = 3'b101,
   parameter logic [W-1:0] TAPS = 3'b110
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic         step,
   output logic [W-1:0] q
);
   if (W < 2) begin : g_bad_w
      $error("pattern register needs at least two stages");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("pattern seed must be nonzero");
   end

   logic          fb;
   logic [W-1:0]  nxt;

   assign fb  = ^(q & TAPS);
   assign nxt = {q[W-2:0], fb};

   always_ff @(posedge clk) begin
      if (rst || load) q <= SEED;
      else if (step)   q <= nxt;
   end

   p_nonzero_r3: assert property (@(posedge clk) disable iff (rst) q != '0)
      else $error("pattern register reached zero");
   p_load_seed_r2: assert property (@(posedge clk) disable iff (rst) load |=> q == SEED)
      else $error("pattern register not seeded");
endmodule

// File: rtl/bist_nand_cut.sv
module bist_nand_cut
   import bist_pkg::*;
(
   input  logic [CUT_IN-1:0]  pat,
   input  fault_e             fault,
   output logic [CUT_OUT-1:0] y
);
   logic a, b, c;
   logic n1, n2, n3;
   logic g2_in;

   assign a = pat[2];
   assign b = pat[1];
   assign c = pat[0];

   assign n1 = ~(a & b);

   always_comb begin
      unique case (fault)
         FLT_SA1: g2_in = 1'b1;
         FLT_SA0: g2_in = 1'b0;
         default: g2_in = n1;
      endcase
   end

   assign n2 = ~(g2_in & c);
   assign n3 = ~(n1 & n2);
   assign y  = {n3, n2, n1};
endmodule

// File: rtl/bist_sig_reg.sv
module bist_sig_reg #(
   parameter int           W    = 3,
   parameter int           M    = 3,
   parameter logic [W-1:0] SEED = 3'b101,
   parameter logic [W-1:0] TAPS = 3'b100
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic         step,
   input  logic [M-1:0] d,
   output logic [W-1:0] q
);
   if (M > W) begin : g_bad_m
      $error("more inputs than signature stages");
   end
   if (W < 2) begin : g_bad_w
      $error("signature register needs at least two stages");
   end

   logic [W-1:0] nxt;
   logic [W-1:0] din;
   logic         msb;

   assign msb = q[W-1];

   for (genvar i = 0; i < W; i++) begin : g_stage
      if (i < M) begin : g_in
         assign din[i] = d[i];
      end else begin : g_noin
         assign din[i] = 1'b0;
      end
      if (i == 0) begin : g_first
         assign nxt[i] = msb ^ din[i];
      end else if (TAPS[i]) begin : g_tap
         assign nxt[i] = q[i-1] ^ msb ^ din[i];
      end else begin : g_plain
         assign nxt[i] = q[i-1] ^ din[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst || load) q <= SEED;
      else if (step)   q <= nxt;
   end

   p_seed_r2: assert property (@(posedge clk) disable iff (rst) load |=> q == SEED)
      else $error("signature not seeded");
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst) (!load && !step) |=> $stable(q))
      else $error("signature moved while idle");
endmodule

// File: rtl/bist_seq.sv
module bist_seq
   import bist_pkg::*;
#(
   parameter int N_PAT = 7
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic load,
   output logic busy,
   output logic last,
   output logic done
);
   localparam int CW = (N_PAT > 1) ? $clog2(N_PAT) : 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(N_PAT - 1);

   if (N_PAT < 2) begin : g_bad_n
      $error("at least two patterns are required");
   end

   seq_e          st;
   logic [CW-1:0] cnt;

   assign busy = (st == SEQ_RUN);
   assign load = start && (st == SEQ_IDLE);
   assign last = busy && (cnt == LAST_CNT);

   always_ff @(posedge clk) begin
      if (rst) begin
         st   <= SEQ_IDLE;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            st  <= SEQ_RUN;
            cnt <= '0;
         end else if (busy) begin
            if (last) begin
               st   <= SEQ_IDLE;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   p_start_r2: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy)
      else $error("start not accepted");
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst) done |=> !done)
      else $error("done longer than one cycle");
   p_done_end_r6: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy)))
      else $error("done not at end of run");
   p_ignore_start_r10: assert property (@(posedge clk) disable iff (rst) (busy && !last) |=> busy)
      else $error("run cut short");
endmodule

// File: rtl/bist_misr_top.sv
module bist_misr_top
   import bist_pkg::*;
#(
   parameter int               SIG_W    = 3,
   parameter logic [CUT_IN-1:0] PAT_SEED = 3'b101,
   parameter logic [CUT_IN-1:0] PAT_TAPS = 3'b110,
   parameter logic [SIG_W-1:0] SIG_SEED = 3'b101,
   parameter logic [SIG_W-1:0] SIG_TAPS = 3'b100,
   parameter logic [SIG_W-1:0] GOLDEN   = 3'b111
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [1:0]       fault_sel,
   output logic             busy,
   output logic             done,
   output logic             pass,
   output logic             fail,
   output logic [SIG_W-1:0] signature
);
   localparam int N_PAT = (1 << CUT_IN) - 1;

   if (SIG_W < CUT_OUT) begin : g_bad_sig
      $error("signature narrower than network outputs");
   end

   logic               load, last;
   logic [CUT_IN-1:0]  pat;
   logic [CUT_OUT-1:0] resp;
   logic               vld;
   logic               match;
   fault_e             fault;

   assign fault = fault_e'(fault_sel);

   bist_seq #(.N_PAT(N_PAT)) u_seq (
      .clk(clk), .rst(rst), .start(start),
      .load(load), .busy(busy), .last(last), .done(done)
   );

   bist_pattern_lfsr #(.W(CUT_IN), .SEED(PAT_SEED), .TAPS(PAT_TAPS)) u_pat (
      .clk(clk), .rst(rst), .load(load), .step(busy), .q(pat)
   );

   bist_nand_cut u_cut (.pat(pat), .fault(fault), .y(resp));

   bist_sig_reg #(.W(SIG_W), .M(CUT_OUT), .SEED(SIG_SEED), .TAPS(SIG_TAPS)) u_sig (
      .clk(clk), .rst(rst), .load(load), .step(busy), .d(resp), .q(signature)
   );

   always_ff @(posedge clk) begin
      if (rst || load) vld <= 1'b0;
      else if (last)   vld <= 1'b1;
   end

   assign match = (signature == GOLDEN);
   assign pass  = vld && match;
   assign fail  = vld && !match;

   p_excl_r8: assert property (@(posedge clk) disable iff (rst) !(pass && fail))
      else $error("pass and fail together");
   p_verdict_at_done_r8: assert property (@(posedge clk) disable iff (rst) done |-> (pass || fail))
      else $error("no verdict at done");
   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
                               (!busy && !start) |=> ($stable(pass) && $stable(fail)))
      else $error("verdict changed while idle");
   p_clear_r2: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> (!pass && !fail))
      else $error("verdict not cleared at start");
endmodule

// File: tb/bist_misr_top_bench.sv
module bist_misr_top_bench;
   localparam int CLK_P = 10;

   function automatic logic [2:0] m_lfsr(input logic [2:0] q);
      return {q[1:0], q[2] ^ q[1]};
   endfunction

   function automatic logic [2:0] m_cut(input logic [2:0] p, input logic [1:0] f);
      logic n1, g, n2, n3;
      n1 = ~(p[2] & p[1]);
      g  = (f == 2'd1) ? 1'b1 : (f == 2'd2) ? 1'b0 : n1;
      n2 = ~(g & p[0]);
      n3 = ~(n1 & n2);
      return {n3, n2, n1};
   endfunction

   function automatic logic [2:0] m_sig(input logic [2:0] q, input logic [2:0] d);
      return {q[1] ^ q[2] ^ d[2], q[0] ^ d[1], q[2] ^ d[0]};
   endfunction

   function automatic logic [2:0] m_run(input logic [1:0] f);
      logic [2:0] s, p;
      s = 3'b101; p = 3'b101;
      for (int k = 0; k < 7; k++) begin
         s = m_sig(s, m_cut(p, f));
         p = m_lfsr(p);
      end
      return s;
   endfunction

   localparam logic [2:0] GOLD = m_run(2'd0);

   logic       clk = 1'b0;
   logic       rst;
   logic       start;
   logic [1:0] fault_sel;
   logic       busy, done, pass, fail;
   logic [2:0] signature;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   bist_misr_top #(.GOLDEN(GOLD)) u_bist_misr_top (
      .clk(clk), .rst(rst), .start(start), .fault_sel(fault_sel),
      .busy(busy), .done(done), .pass(pass), .fail(fail), .signature(signature)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cyc);
         summary();
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run(input logic [1:0] f, input int poke);
      logic [2:0] s, p, fin;
      @(negedge clk);
      fault_sel = f;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 busy after start", busy, 1);
      chk("R2 signature seeded", signature, 3'b101);
      chk("R2 verdict cleared", {pass, fail}, 2'b00);
      s = 3'b101; p = 3'b101;
      for (int k = 1; k <= 7; k++) begin
         if (k == poke) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         s = m_sig(s, m_cut(p, f));
         p = m_lfsr(p);
         chk("R3 R4 R5 R9 R10 signature step", signature, s);
         chk("R6 busy length", busy, (k < 7));
         chk("R7 done timing", done, (k == 7));
      end
      fin = m_run(f);
      chk("R8 pass", pass, (fin == GOLD));
      chk("R8 fail", fail, (fin != GOLD));
      @(negedge clk);
      chk("R7 done single cycle", done, 0);
      chk("R6 idle after run", busy, 0);
   endtask

   initial begin
      rst = 1'b1; start = 1'b0; fault_sel = 2'd0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 verdict", {pass, fail}, 2'b00);
      chk("R1 signature", signature, 3'b101);

      run(2'd0, 0);
      chk("R8 golden pass", pass, 1);

      run(2'd1, 0);
      chk("R11 stuck-at-1 fails", fail, 1);
      chk("R11 stuck-at-1 differs", (signature != GOLD), 1);
      chk("R9 stuck-at-1 value", signature, m_run(2'd1));

      run(2'd2, 0);
      chk("R11 stuck-at-0 fails", fail, 1);
      chk("R11 stuck-at-0 differs", (signature != GOLD), 1);
      chk("R9 stuck-at-0 distinct", (m_run(2'd2) != m_run(2'd1)), 1);

      run(2'd3, 0);
      chk("R9 code 3 as none", pass, 1);

      for (int k = 1; k <= 6; k++) run(2'd0, k);
      chk("R10 final after mid-run starts", signature, GOLD);

      run(2'd2, 4);
      repeat (5) begin
         @(negedge clk);
         chk("R8 fail held", {pass, fail}, 2'b01);
         chk("R8 signature held", signature, m_run(2'd2));
         chk("R6 stays idle", busy, 0);
      end

      summary();
   end
endmodule